// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a virtual address into a physical address using a table that holds one entry per physical frame instead of one entry per virtual page. The virtual page number is folded by a hash into a frame index. The entry at that index holds the virtual page number that currently occupies the frame. If that stored number equals the requested one, the index itself is the frame number. The physical address is then that index placed above the untouched page offset.

Each entry carries three things: an occupied flag, a resident flag and the stored page tag. A request whose tag disagrees with the entry, or whose entry was never filled, is reported as a miss. The full page table kept in backing storage then has to serve it. A request whose tag agrees but whose frame has been evicted is reported as a page fault. Software fills entries through an install port and evicts frames through a separate invalidate port.

The lookup is a single probe with a registered result, so one answer comes back per request with one cycle of latency.

Top module: `ipt_lookup`

## Requirements
- R1: The table index is the low FRAME_W bits of the XOR of the upper half and the lower half of the virtual page number. The virtual page number is the address bits above the OFF_W offset bits.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise.
- R3: While rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is high. While rsp_valid is low, all three are low.
- R4: A hit occurs when the indexed entry is occupied, holds the requested page number and is resident. rsp_paddr is then the index concatenated with the request's page offset.
- R5: A request is reported as a miss, with rsp_paddr zero, when its entry was never installed or when the stored tag differs from the request.
- R6: A request is reported as a fault, with rsp_paddr zero, when the stored tag matches but the resident flag is clear.
- R7: An install writes the given page tag into the given frame and marks the frame both occupied and resident.
- R8: An invalidate clears only the resident flag of the given frame. The stored tag is kept, so a later request for that page reports a fault.
- R9: When an install and an invalidate name the same frame in the same cycle, the install takes effect.
- R10: A lookup issued in the same cycle as a write to its entry reports the entry's contents from before that write.
- R11: Reset leaves every entry unoccupied and all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| ins_valid | input | 1 | Install strobe |
| ins_frame | input | FRAME_W | Frame index to install into |
| ins_vpn | input | VPN_W | Virtual page number to store |
| inv_valid | input | 1 | Invalidate strobe |
| inv_frame | input | FRAME_W | Frame index to evict |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found and resident |
| rsp_miss | output | 1 | No matching entry; the backing table must serve it |
| rsp_fault | output | 1 | Entry matches but the page is not resident |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address on a hit, zero otherwise |

## Verification
Two different pages that fold to the same index are used to confirm that the tag comparison really decides a hit. A design that compared only the index would call the second page a hit. A freshly reset table is probed at page zero, because a design with no occupied flag would match the cleared tag and report a fault or a hit instead of a miss. Eviction is followed by a probe of the same page to separate a fault from a miss, which a design that cleared the tag would get wrong. A lookup overlapped with an install, and an install overlapped with an invalidate of the same frame, pin down read-before-write behaviour and write priority. A design that read after writing, or that let the invalidate win, would report the opposite outcome.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;
   typedef enum logic [1:0] {
      KIND_MISS  = 2'd0,
      KIND_HIT   = 2'd1,
      KIND_FAULT = 2'd2
   } probe_kind_e;
endpackage

// File: rtl/ipt_hash.sv
`timescale 1ns/1ps
module ipt_hash #(
   parameter int VPN_W     = 16,
   parameter int FRAME_W   = 6,
   parameter bit HASH_FOLD = 1'b1
) (
   input  logic [VPN_W-1:0]   vpn_i,
   output logic [FRAME_W-1:0] idx_o
);
   localparam int HALF_W = VPN_W / 2;

   if ((VPN_W % 2) != 0) begin : g_odd_vpn
      $error("ipt_hash: VPN_W must be even");
   end
   if (FRAME_W > HALF_W) begin : g_wide_idx
      $error("ipt_hash: FRAME_W must not exceed VPN_W/2");
   end

   if (HASH_FOLD) begin : g_fold
      logic [HALF_W-1:0] folded;
      assign folded = vpn_i[VPN_W-1:HALF_W] ^ vpn_i[HALF_W-1:0];
      assign idx_o  = folded[FRAME_W-1:0];
   end else begin : g_direct
      assign idx_o = vpn_i[FRAME_W-1:0];
   end
endmodule

// File: rtl/ipt_entry_store.sv
`timescale 1ns/1ps
module ipt_entry_store #(
   parameter int VPN_W   = 16,
   parameter int FRAME_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FRAME_W-1:0] wr_idx,
   input  logic [VPN_W-1:0]   wr_tag,
   input  logic               clr_en,
   input  logic [FRAME_W-1:0] clr_idx,
   input  logic [FRAME_W-1:0] rd_idx,
   output logic               rd_occ,
   output logic               rd_res,
   output logic [VPN_W-1:0]   rd_tag
);
   localparam int N_FRAMES = 1 << FRAME_W;

   logic [VPN_W-1:0] tag_arr [N_FRAMES];
   logic             occ_arr [N_FRAMES];
   logic             res_arr [N_FRAMES];

   for (genvar e = 0; e < N_FRAMES; e++) begin : g_ent
      logic [VPN_W-1:0] tag_q;
      logic             occ_q;
      logic             res_q;
      logic             hit_wr;
      logic             hit_clr;

      assign hit_wr  = wr_en  && (wr_idx  == FRAME_W'(e));
      assign hit_clr = clr_en && (clr_idx == FRAME_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q <= '0;
            occ_q <= 1'b0;
            res_q <= 1'b0;
         end else if (hit_wr) begin
            tag_q <= wr_tag;
            occ_q <= 1'b1;
            res_q <= 1'b1;
         end else if (hit_clr) begin
            res_q <= 1'b0;
         end
      end

      assign tag_arr[e] = tag_q;
      assign occ_arr[e] = occ_q;
      assign res_arr[e] = res_q;
   end

   assign rd_tag = tag_arr[rd_idx];
   assign rd_occ = occ_arr[rd_idx];
   assign rd_res = res_arr[rd_idx];
endmodule

// File: rtl/ipt_classify.sv
`timescale 1ns/1ps
module ipt_classify
   import ipt_pkg::*;
#(
   parameter int VPN_W = 16
) (
   input  logic             occ_i,
   input  logic             res_i,
   input  logic [VPN_W-1:0] tag_i,
   input  logic [VPN_W-1:0] req_tag_i,
   output probe_kind_e      kind_o
);
   always_comb begin
      if (!occ_i || (tag_i != req_tag_i)) kind_o = KIND_MISS;
      else if (!res_i)                    kind_o = KIND_FAULT;
      else                                kind_o = KIND_HIT;
   end
endmodule

// File: rtl/ipt_lookup.sv
`timescale 1ns/1ps
module ipt_lookup
   import ipt_pkg::*;
#(
   parameter int VPN_W     = 16,
   parameter int OFF_W     = 12,
   parameter int FRAME_W   = 6,
   parameter bit HASH_FOLD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
   input  logic                     ins_valid,
   input  logic [FRAME_W-1:0]       ins_frame,
   input  logic [VPN_W-1:0]         ins_vpn,
   input  logic                     inv_valid,
   input  logic [FRAME_W-1:0]       inv_frame,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic                     rsp_miss,
   output logic                     rsp_fault,
   output logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
   localparam int VA_W = VPN_W + OFF_W;
   localparam int PA_W = FRAME_W + OFF_W;

   if (OFF_W < 1) begin : g_bad_off
      $error("ipt_lookup: OFF_W must be at least 1");
   end

   logic [VPN_W-1:0]   req_vpn;
   logic [OFF_W-1:0]   req_off;
   logic [FRAME_W-1:0] look_idx;
   logic               ent_occ;
   logic               ent_res;
   logic [VPN_W-1:0]   ent_tag;
   probe_kind_e        kind;

   assign req_vpn = req_vaddr[VA_W-1:OFF_W];
   assign req_off = req_vaddr[OFF_W-1:0];

   ipt_hash #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .HASH_FOLD(HASH_FOLD)) u_hash (
      .vpn_i (req_vpn),
      .idx_o (look_idx)
   );

   ipt_entry_store #(.VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ins_valid),
      .wr_idx  (ins_frame),
      .wr_tag  (ins_vpn),
      .clr_en  (inv_valid),
      .clr_idx (inv_frame),
      .rd_idx  (look_idx),
      .rd_occ  (ent_occ),
      .rd_res  (ent_res),
      .rd_tag  (ent_tag)
   );

   ipt_classify #(.VPN_W(VPN_W)) u_cls (
      .occ_i     (ent_occ),
      .res_i     (ent_res),
      .tag_i     (ent_tag),
      .req_tag_i (req_vpn),
      .kind_o    (kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && (kind == KIND_HIT);
         rsp_miss  <= req_valid && (kind == KIND_MISS);
         rsp_fault <= req_valid && (kind == KIND_FAULT);
         rsp_paddr <= (req_valid && (kind == KIND_HIT)) ? {look_idx, req_off} : PA_W'(0);
      end
   end
endmodule

// File: rtl/ipt_lookup_chk.sv
`timescale 1ns/1ps
module ipt_lookup_chk #(
   parameter int VPN_W   = 16,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic [VPN_W+OFF_W-1:0]   req_vaddr,
   input logic                     rsp_valid,
   input logic                     rsp_hit,
   input logic                     rsp_miss,
   input logic                     rsp_fault,
   input logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));
   a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
   a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))));
   a_r5_paddr_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0));
   a_r6_paddr_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0));
endmodule

bind ipt_lookup ipt_lookup_chk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_vaddr (req_vaddr),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr)
);

// File: tb/ipt_lookup_bench.sv
`timescale 1ns/1ps
module ipt_lookup_bench;
   localparam int VPN_W   = 16;
   localparam int OFF_W   = 12;
   localparam int FRAME_W = 6;
   localparam int VA_W    = VPN_W + OFF_W;
   localparam int PA_W    = FRAME_W + OFF_W;
   localparam int NF      = 1 << FRAME_W;
   localparam int HALF_W  = VPN_W / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic ins_valid = 1'b0;
   logic [FRAME_W-1:0] ins_frame = '0;
   logic [VPN_W-1:0] ins_vpn = '0;
   logic inv_valid = 1'b0;
   logic [FRAME_W-1:0] inv_frame = '0;
   logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
   logic [PA_W-1:0] rsp_paddr;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   logic [VPN_W-1:0] m_tag [NF];
   logic             m_occ [NF];
   logic             m_res [NF];

   always #2.5 clk = ~clk;

   ipt_lookup #(.VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_ipt_lookup (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .ins_valid(ins_valid), .ins_frame(ins_frame), .ins_vpn(ins_vpn),
      .inv_valid(inv_valid), .inv_frame(inv_frame),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
   );

   // R1 index function, written from the requirement
   function automatic logic [FRAME_W-1:0] idx_of(input logic [VPN_W-1:0] v);
      logic [HALF_W-1:0] f;
      f = v[VPN_W-1:HALF_W] ^ v[HALF_W-1:0];
      return f[FRAME_W-1:0];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // expected {valid,hit,miss,fault} and paddr from the model (state before any same-cycle write)
   task automatic expect_for(input logic [VA_W-1:0] va, output logic [3:0] flags,
                             output logic [PA_W-1:0] pa);
      logic [VPN_W-1:0] v;
      logic [FRAME_W-1:0] ix;
      v  = va[VA_W-1:OFF_W];
      ix = idx_of(v);
      pa = '0;
      if (!m_occ[ix] || m_tag[ix] != v) flags = 4'b1010;
      else if (!m_res[ix]) flags = 4'b1001;
      else begin
         flags = 4'b1100;
         pa = {ix, va[OFF_W-1:0]};
      end
   endtask

   task automatic check_rsp(input string req, input logic [3:0] ef, input logic [PA_W-1:0] ep);
      chk({req, " flags"}, {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, {28'd0, ef});
      chk({req, " paddr"}, 32'(rsp_paddr), 32'(ep));
   endtask

   task automatic do_install(input logic [FRAME_W-1:0] f, input logic [VPN_W-1:0] v);
      @(negedge clk);
      ins_valid = 1'b1; ins_frame = f; ins_vpn = v;
      @(negedge clk);
      ins_valid = 1'b0;
      m_tag[f] = v; m_occ[f] = 1'b1; m_res[f] = 1'b1;
   endtask

   task automatic do_invalidate(input logic [FRAME_W-1:0] f);
      @(negedge clk);
      inv_valid = 1'b1; inv_frame = f;
      @(negedge clk);
      inv_valid = 1'b0;
      m_res[f] = 1'b0;
   endtask

   task automatic do_lookup(input string req, input logic [VA_W-1:0] va);
      logic [3:0] ef;
      logic [PA_W-1:0] ep;
      expect_for(va, ef, ep);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(req, ef, ep);
   endtask

   task automatic t_reset;
      chk("R11 reset valid", {31'd0, rsp_valid}, 32'd0);
      chk("R11 reset flags", {29'd0, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
      do_lookup("R11 R5 empty page0 miss", 28'h0000_123);
      do_lookup("R5 empty miss", 28'h1203_456);
   endtask

   task automatic t_hit_and_alias;
      do_install(idx_of(16'h1203), 16'h1203);
      do_lookup("R7 R4 hit after install", 28'h1203_abc);
      chk("R1 frame field", 32'(rsp_paddr[PA_W-1:OFF_W]), 32'h11);
      do_lookup("R5 alias tag mismatch miss", 28'h0312_abc);
   endtask

   task automatic t_evict;
      do_invalidate(6'h11);
      do_lookup("R8 R6 fault after evict", 28'h1203_777);
      do_lookup("R5 alias still miss", 28'h0312_777);
      do_install(6'h11, 16'h1203);
      do_lookup("R7 reinstall hit", 28'h1203_001);
   endtask

   task automatic t_overlap_lookup;
      logic [3:0] ef;
      logic [PA_W-1:0] ep;
      expect_for(28'h0312_555, ef, ep);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 28'h0312_555;
      ins_valid = 1'b1; ins_frame = 6'h11; ins_vpn = 16'h0312;
      @(negedge clk);
      req_valid = 1'b0; ins_valid = 1'b0;
      check_rsp("R10 lookup sees pre-install", ef, ep);
      m_tag[6'h11] = 16'h0312; m_occ[6'h11] = 1'b1; m_res[6'h11] = 1'b1;
      do_lookup("R10 R7 next lookup sees install", 28'h0312_555);
   endtask

   task automatic t_priority;
      @(negedge clk);
      ins_valid = 1'b1; ins_frame = 6'h3f; ins_vpn = 16'hffc0;
      inv_valid = 1'b1; inv_frame = 6'h3f;
      @(negedge clk);
      ins_valid = 1'b0; inv_valid = 1'b0;
      m_tag[6'h3f] = 16'hffc0; m_occ[6'h3f] = 1'b1; m_res[6'h3f] = 1'b1;
      do_lookup("R9 install beats invalidate", 28'hffc0_fff);
      chk("R1 top index", 32'(rsp_paddr), 32'h3ffff);
   endtask

   task automatic t_back_to_back;
      logic [3:0] ea, eb;
      logic [PA_W-1:0] pa, pb;
      expect_for(28'hffc0_010, ea, pa);
      expect_for(28'h4444_020, eb, pb);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 28'hffc0_010;
      @(negedge clk);
      req_vaddr = 28'h4444_020;
      check_rsp("R2 first of pair", ea, pa);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp("R2 second of pair", eb, pb);
      @(negedge clk);
      chk("R2 R3 idle after pair", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NF; i++) begin
         m_tag[i] = '0; m_occ[i] = 1'b0; m_res[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hit_and_alias();
      t_evict();
      t_overlap_lookup();
      t_priority();
      t_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule